// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block runs single read and write transfers on an asynchronous external bus that serves eight chip selects. An internal master hands over one request at a time. The sequencer then drives the chosen chip select and the read or write strobe through five timed phases: address, setup, strobe, hold and recovery. The length of each phase is set per chip select by a static configuration vector. When the recovery phase ends, it returns a one-cycle acknowledge carrying the captured read data.

Slow devices can stretch the strobe of a read with a shared active-low wait line. A device that drops wait and then releases it cuts the strobe short at once, whatever strobe length is programmed. The upper four chip selects can each be switched into a host-port mode. In that mode the select ignores the wait line and uses its own ready line, with a programmable active level. The ready line stretches both reads and writes. Every wait and ready input passes through a two-flop synchronizer before the state machine uses it.

The request side follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so a master holding `req_valid` simply waits. The master keeps its request fields stable until the request is taken. The response is a one-cycle `rsp_valid` pulse with no back-pressure, because the bus transfer has already finished by then.

Top module: `ebus_seq`

## Requirements
- R1: After reset, all `ext_cs_n` bits, `ext_rd_n` and `ext_wr_n` are high, `req_ready` is high and `rsp_valid` is low.
- R2: `req_ready` is high only in the idle state, and a request is accepted only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low on the cycle after an acceptance.
- R3: The phases run in the order address, setup, strobe, hold, recovery. Each phase lasts field+1 cycles (1 to 16). For chip select c, the 4-bit fields sit in `cfg_timing[c*20 +: 20]`: bits [3:0] address, [7:4] setup, [11:8] strobe, [15:12] hold, [19:16] recovery. Without stretching, `rsp_valid` appears the cycle after recovery ends, which is sum of lengths + 1 cycles after acceptance.
- R4: From the address phase through the hold phase, exactly one `ext_cs_n` bit is low: the bit of the requested chip select. All bits are high in idle and recovery.
- R5: `ext_rd_n` is low exactly in the strobe phase of a read, and `ext_wr_n` is low exactly in the strobe phase of a write. The two are never low together.
- R6: For a read on a chip select not in host-port mode, a low `ext_wait_n` (after two synchronizer cycles) keeps the strobe phase going past its programmed length.
- R7: Once wait has been seen low during a read strobe, the strobe ends on the first cycle the synchronized wait is high, even when the programmed strobe count has not expired.
- R8: `ext_wait_n` has no effect on writes, on phases other than the read strobe, or on chip selects in host-port mode.
- R9: When `cfg_host[k]` is 1, chip select 4+k uses `ext_rdy[k]`, and its active level is `cfg_rdy_pol` (1 = active high). The strobe of a read or a write is held until the synchronized ready is active. A ready release after a stall ends the strobe at once.
- R10: Read data on `ext_rdata` is captured on the last strobe cycle and returned on `rsp_rdata` with a one-cycle `rsp_valid` pulse on the cycle after recovery ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_timing | input | NCS*20 | Per-select phase lengths, 4 bits each, stored as length-1 |
| cfg_host | input | NHOST | Host-port mode enable for chip selects 4..7 |
| cfg_rdy_pol | input | 1 | Active level of the ready inputs |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_cs | input | 3 | Target chip select |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Captured read data |
| ext_cs_n | output | NCS | Active-low chip selects |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_addr | output | AW | Address held for the transfer |
| ext_wdata | output | DW | Write data held for the transfer |
| ext_rdata | input | DW | Read data from the bus |
| ext_wait_n | input | 1 | Shared active-low wait, asynchronous |
| ext_rdy | input | NHOST | Per-select host-port ready lines, asynchronous |

## Verification
The assertions assume that the configuration inputs stay constant from acceptance to acknowledge. They also assume that the master raises `req_valid` only with stable request fields. Wait and ready may change at any time, since they are synchronized, but the stimulus changes them only between clock edges. The bench changes `cfg_timing`, `cfg_host` and `cfg_rdy_pol` only while the sequencer is idle. It lets the synchronizers settle for several cycles before each stalled transfer, so that every stall starts from a known level.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SETUP,
    PH_STRB,
    PH_HOLD,
    PH_RECOV
  } phase_e;

  localparam int PHASES = 5;
  localparam int CW     = 4;
  localparam int CFG_W  = PHASES * CW;

  localparam int F_ADDR  = 0;
  localparam int F_SETUP = 1;
  localparam int F_STRB  = 2;
  localparam int F_HOLD  = 3;
  localparam int F_RECOV = 4;
endpackage

// File: rtl/ebus_sync.sv
module ebus_sync #(
  parameter int           W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1 <= RST;
      q    <= RST;
    end else begin
      stg1 <= d;
      q    <= stg1;
    end
  end
endmodule

// File: rtl/ebus_cfg_mux.sv
module ebus_cfg_mux
  import ebus_pkg::*;
#(
  parameter int NCS = 8,
  localparam int CSW = $clog2(NCS)
) (
  input  logic [NCS*CFG_W-1:0]      cfg_flat,
  input  logic [CSW-1:0]            sel,
  output logic [PHASES-1:0][CW-1:0] len_o
);
  logic [CFG_W-1:0] tbl [NCS];

  for (genvar g = 0; g < NCS; g++) begin : g_unpack
    assign tbl[g] = cfg_flat[g*CFG_W +: CFG_W];
  end

  assign len_o = tbl[sel];
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int NCS   = 8,
  parameter int NHOST = 4,
  parameter int AW    = 16,
  parameter int DW    = 16,
  localparam int CSW   = $clog2(NCS),
  localparam int HBASE = NCS - NHOST
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCS*CFG_W-1:0] cfg_timing,
  input  logic [NHOST-1:0]     cfg_host,
  input  logic                 cfg_rdy_pol,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [CSW-1:0]       req_cs,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  output logic [NCS-1:0]       ext_cs_n,
  output logic                 ext_rd_n,
  output logic                 ext_wr_n,
  output logic [AW-1:0]        ext_addr,
  output logic [DW-1:0]        ext_wdata,
  input  logic [DW-1:0]        ext_rdata,
  input  logic                 ext_wait_n,
  input  logic [NHOST-1:0]     ext_rdy
);
  phase_e                    ph_q;
  logic [CW-1:0]             cnt_q;
  logic                      seen_q;
  logic [CSW-1:0]            cs_q;
  logic                      wr_q;
  logic [AW-1:0]             addr_q;
  logic [DW-1:0]             wdata_q;
  logic [DW-1:0]             rdata_q;
  logic                      ack_q;
  logic                      wait_s;
  logic [NHOST-1:0]          rdy_s;
  logic [CSW-1:0]            cfg_sel;
  logic [PHASES-1:0][CW-1:0] len;
  logic                      is_host;
  logic                      rdy_act;
  logic                      stall;
  logic                      strb_done;

  ebus_sync #(.W(1), .RST(1'b1)) u_wait_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_wait_n), .q(wait_s)
  );

  ebus_sync #(.W(NHOST), .RST('0)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_rdy), .q(rdy_s)
  );

  assign cfg_sel = (ph_q == PH_IDLE) ? req_cs : cs_q;

  ebus_cfg_mux #(.NCS(NCS)) u_cfg_mux (
    .cfg_flat(cfg_timing), .sel(cfg_sel), .len_o(len)
  );

  // host-port lookup for the latched chip select
  always_comb begin
    is_host = 1'b0;
    rdy_act = 1'b0;
    for (int k = 0; k < NHOST; k++) begin
      if (cs_q == CSW'(HBASE + k)) begin
        is_host = cfg_host[k];
        rdy_act = (rdy_s[k] == cfg_rdy_pol);
      end
    end
  end

  assign stall     = is_host ? !rdy_act : (!wr_q && !wait_s);
  assign strb_done = !stall && ((cnt_q == '0) || seen_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      cs_q    <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (req_valid) begin
          cs_q    <= req_cs;
          wr_q    <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          cnt_q   <= len[F_ADDR];
          ph_q    <= PH_ADDR;
        end
        PH_ADDR: if (cnt_q == '0) begin
          cnt_q <= len[F_SETUP];
          ph_q  <= PH_SETUP;
        end else cnt_q <= cnt_q - 1'b1;
        PH_SETUP: if (cnt_q == '0) begin
          cnt_q  <= len[F_STRB];
          seen_q <= 1'b0;
          ph_q   <= PH_STRB;
        end else cnt_q <= cnt_q - 1'b1;
        PH_STRB: if (strb_done) begin
          cnt_q <= len[F_HOLD];
          ph_q  <= PH_HOLD;
          if (!wr_q) rdata_q <= ext_rdata;
        end else begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          if (stall) seen_q <= 1'b1;
        end
        PH_HOLD: if (cnt_q == '0) begin
          cnt_q <= len[F_RECOV];
          ph_q  <= PH_RECOV;
        end else cnt_q <= cnt_q - 1'b1;
        PH_RECOV: if (cnt_q == '0) begin
          ack_q <= 1'b1;
          ph_q  <= PH_IDLE;
        end else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  logic cs_on;
  assign cs_on = (ph_q == PH_ADDR) || (ph_q == PH_SETUP) ||
                 (ph_q == PH_STRB) || (ph_q == PH_HOLD);

  for (genvar c = 0; c < NCS; c++) begin : g_cs
    assign ext_cs_n[c] = !(cs_on && (cs_q == CSW'(c)));
  end

  assign ext_rd_n  = !((ph_q == PH_STRB) && !wr_q);
  assign ext_wr_n  = !((ph_q == PH_STRB) && wr_q);
  assign ext_addr  = addr_q;
  assign ext_wdata = wdata_q;
  assign req_ready = (ph_q == PH_IDLE);
  assign rsp_valid = ack_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk #(
  parameter int NCS = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           rsp_valid,
  input logic [NCS-1:0] ext_cs_n,
  input logic           ext_rd_n,
  input logic           ext_wr_n
);
  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n));

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));

  a_r5_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> !(&ext_cs_n));

  a_r2_idle_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&ext_cs_n));

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind ebus_seq ebus_seq_chk #(.NCS(NCS)) u_ebus_seq_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
  .ext_wr_n(ext_wr_n)
);

// File: tb/ebus_seq_tb.sv
module ebus_seq_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [159:0] cfg_timing = '0;
  logic [3:0]   cfg_host = 4'b0010;
  logic         cfg_rdy_pol = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [2:0]   req_cs = '0;
  logic         req_write = 1'b0;
  logic [15:0]  req_addr = '0;
  logic [15:0]  req_wdata = '0;
  logic         rsp_valid;
  logic [15:0]  rsp_rdata;
  logic [7:0]   ext_cs_n;
  logic         ext_rd_n, ext_wr_n;
  logic [15:0]  ext_addr, ext_wdata;
  logic [15:0]  ext_rdata = 16'h1234;
  logic         ext_wait_n = 1'b1;
  logic [3:0]   ext_rdy = 4'h0;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_en = 0;

  always #4 clk = ~clk;

  ebus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_timing(cfg_timing), .cfg_host(cfg_host),
    .cfg_rdy_pol(cfg_rdy_pol), .req_valid(req_valid), .req_ready(req_ready),
    .req_cs(req_cs), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .ext_wait_n(ext_wait_n), .ext_rdy(ext_rdy)
  );

  task automatic chk(input bit ok, input string rq,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle,1 addr,2 setup,3 strobe,4 hold,5 recovery
  int          m_ph, m_cnt, m_cs;
  bit          m_wr, m_seen, m_ack, m_w1, m_w2, m_stall, m_host;
  bit [3:0]    m_r1, m_r2;
  logic [15:0] m_rd;

  function automatic int fld(int cs, int p);
    return int'(cfg_timing[cs*20 + p*4 +: 4]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_cs = 0; m_wr = 0; m_seen = 0; m_ack = 0;
      m_w1 = 1; m_w2 = 1; m_r1 = 0; m_r2 = 0; m_rd = 0;
    end else begin
      m_ack = 0;
      m_host = (m_cs >= 4) && cfg_host[m_cs-4];
      m_stall = m_host ? (m_r2[m_cs-4] != cfg_rdy_pol) : (!m_wr && !m_w2);
      case (m_ph)
        0: if (req_valid) begin
             m_cs = int'(req_cs); m_wr = req_write; m_cnt = fld(m_cs, 0); m_ph = 1;
           end
        1, 2, 4: if (m_cnt == 0) begin
             m_ph = m_ph + 1; m_cnt = fld(m_cs, m_ph - 1); m_seen = 0;
           end else m_cnt--;
        3: if (!m_stall && (m_cnt == 0 || m_seen)) begin
             m_ph = 4; m_cnt = fld(m_cs, 3);
             if (!m_wr) m_rd = ext_rdata;
           end else begin
             if (m_cnt > 0) m_cnt--;
             if (m_stall) m_seen = 1;
           end
        default: if (m_cnt == 0) begin m_ph = 0; m_ack = 1; end else m_cnt--;
      endcase
      m_w2 = m_w1; m_w1 = ext_wait_n; m_r2 = m_r1; m_r1 = ext_rdy;
    end
  end

  always @(negedge clk) ext_rdata <= ext_rdata + 16'h0107;

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      logic [7:0] e_cs;
      e_cs = 8'hFF;
      if (m_ph >= 1 && m_ph <= 4) e_cs[m_cs] = 1'b0;
      chk(ext_cs_n == e_cs, "R4 chip select", 32'(ext_cs_n), 32'(e_cs));
      chk(ext_rd_n == !(m_ph == 3 && !m_wr), "R5 read strobe", 32'(ext_rd_n),
          32'(!(m_ph == 3 && !m_wr)));
      chk(ext_wr_n == !(m_ph == 3 && m_wr), "R5 write strobe", 32'(ext_wr_n),
          32'(!(m_ph == 3 && m_wr)));
      chk(req_ready == (m_ph == 0), "R2 ready", 32'(req_ready), 32'(m_ph == 0));
      chk(rsp_valid == m_ack, "R10 ack", 32'(rsp_valid), 32'(m_ack));
      if (m_ack && !m_wr)
        chk(rsp_rdata == m_rd, "R10 read data", 32'(rsp_rdata), 32'(m_rd));
    end
  end

  task automatic set_cfg(input int cs, input int a, input int s, input int t,
                         input int h, input int r);
    cfg_timing[cs*20 +: 20] = {4'(r-1), 4'(h-1), 4'(t-1), 4'(s-1), 4'(a-1)};
  endtask

  task automatic idle_inputs(input int n);
    ext_wait_n = 1'b1;
    ext_rdy = {4{cfg_rdy_pol}};
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int cs, input bit wr, input int rel,
                      output int slen, output int tot);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cs = 3'(cs); req_write = wr;
    req_addr = 16'(cs * 17 + 7); req_wdata = 16'hA500 + 16'(cs);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 busy after accept", 32'(req_ready), 32'h0);
    chk(ext_cs_n == 8'(~(8'd1 << cs)), "R4 select in address phase",
        32'(ext_cs_n), 32'(8'(~(8'd1 << cs))));
    slen = 0; tot = 1;
    for (int i = 0; i < 400 && !rsp_valid; i++) begin
      @(negedge clk);
      tot++;
      if (!ext_rd_n || !ext_wr_n) begin
        slen++;
        if (rel > 0 && slen == rel) begin
          ext_wait_n = 1'b1;
          ext_rdy = {4{cfg_rdy_pol}};
        end
      end
    end
  endtask

  initial begin
    int sl, tt;
    for (int c = 0; c < 8; c++) set_cfg(c, 1, 2, 3, 1, 2);
    set_cfg(0, 2, 3, 4, 2, 3);
    set_cfg(1, 1, 1, 1, 1, 1);
    set_cfg(2, 16, 16, 16, 16, 16);
    set_cfg(3, 1, 1, 3, 1, 1);
    set_cfg(4, 1, 1, 2, 1, 1);
    set_cfg(5, 1, 1, 2, 1, 1);
    set_cfg(6, 1, 1, 16, 1, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ext_cs_n == 8'hFF, "R1 selects idle", 32'(ext_cs_n), 32'hFF);
    chk(ext_rd_n && ext_wr_n, "R1 strobes idle", {ext_rd_n, ext_wr_n}, 32'h3);
    chk(req_ready && !rsp_valid, "R1 ready/ack", {req_ready, rsp_valid}, 32'h2);
    mon_en = 1;
    idle_inputs(3);

    xfer(0, 0, 0, sl, tt);
    chk(sl == 4, "R3 strobe length", sl, 4);
    chk(tt == 15, "R3 total latency", tt, 15);
    xfer(1, 1, 0, sl, tt);
    chk(sl == 1 && tt == 6, "R3 minimum lengths", tt, 6);
    xfer(2, 0, 0, sl, tt);
    chk(sl == 16 && tt == 81, "R3 maximum lengths", tt, 81);

    ext_wait_n = 1'b0; repeat (3) @(negedge clk);
    xfer(3, 1, 0, sl, tt);
    chk(sl == 3, "R8 wait ignored on write", sl, 3);
    idle_inputs(3);

    ext_wait_n = 1'b0; repeat (3) @(negedge clk);
    xfer(4, 0, 6, sl, tt);
    chk(sl == 8, "R6 wait stretches read strobe", sl, 8);
    idle_inputs(3);

    ext_wait_n = 1'b0; repeat (3) @(negedge clk);
    xfer(6, 0, 3, sl, tt);
    chk(sl == 5, "R7 release ends strobe early", sl, 5);
    idle_inputs(3);

    ext_rdy[1] = 1'b1; repeat (3) @(negedge clk);
    xfer(5, 0, 4, sl, tt);
    chk(sl == 6, "R9 host read held by ready", sl, 6);
    idle_inputs(3);

    ext_rdy[1] = 1'b1; repeat (3) @(negedge clk);
    xfer(5, 1, 5, sl, tt);
    chk(sl == 7, "R9 host write held by ready", sl, 7);
    idle_inputs(3);

    ext_wait_n = 1'b0; repeat (3) @(negedge clk);
    xfer(5, 0, 0, sl, tt);
    chk(sl == 2, "R8 wait ignored in host mode", sl, 2);
    idle_inputs(3);

    cfg_rdy_pol = 1'b1;
    ext_rdy = 4'h0; repeat (3) @(negedge clk);
    xfer(5, 0, 2, sl, tt);
    chk(sl == 4, "R9 active-high ready", sl, 4);
    idle_inputs(3);

    xfer(7, 0, 0, sl, tt);
    chk(sl == 3 && tt == 10, "R3 default timing", tt, 10);
    idle_inputs(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule